// File: doc/BRIEF.md
# XOR-Combining Crossbar Output Port

This block is one output port of a single-cycle wormhole router crossbar. Flits do not wait for switch arbitration. In the same cycle that an input raises its request, its flit goes onto the output. When several inputs ask for the port together, the output carries the bitwise XOR of all their flits. A round-robin arbiter runs in parallel with this data path. It never gates the data. It only names the one contender whose flit counts as delivered in that cycle. That input gets a pop pulse so it may advance its queue.

The contenders that lose keep requesting, so each later cycle carries the XOR of a smaller set: A^B^C, then B^C, then C. The last flit of the run goes out uncoded. A receiver rebuilds every delivered flit by XORing two consecutive output words. For this to work, the contender set is frozen while a run is in progress. Any input that starts requesting during a run waits until the frozen set has drained.

Input i uses bit i of `req`, `grant` and `pop`, and bits i*FLIT_W to i*FLIT_W+FLIT_W-1 of `flit_in`. By default there are five inputs (four mesh directions plus local) and flits are 64 bits wide.

Top module: `xor_switch_port`

## Requirements
- R1: When no input is admitted, `out_valid` and `out_coded` are 0, `out_flit` is all zeros, and `grant` and `pop` are all zeros.
- R2: When exactly one input is admitted, `out_flit` equals that input's flit unmodified, `out_valid` is 1, `out_coded` is 0, and that input's `pop` bit is 1 in the same cycle.
- R3: When two or more inputs are admitted, `out_flit` is the bitwise XOR of their flits, and `out_valid` and `out_coded` are both 1.
- R4: In every cycle where `out_valid` is 1, exactly one `pop` bit is set, and it lies inside `grant`.
- R5: Admitted inputs that are not popped stay admitted while they keep requesting. Each following cycle carries the XOR of the remaining flits, and the final one is sent uncoded.
- R6: The popped input is the first admitted index found when searching upward from a priority pointer, wrapping from NUM_IN-1 back to 0. After a pop, the pointer moves to the popped index plus one, modulo NUM_IN.
- R7: While a run is in progress (the previous cycle left admitted inputs that were not popped), an input outside that set gets no `grant` or `pop`, and its flit is left out of `out_flit`.
- R8: Within one run, the XOR of the output words of two consecutive cycles equals the flit of the input popped in the first of those two cycles.
- R9: A synchronous active-high `rst` ends any run in progress and sets the priority pointer to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NUM_IN | Per-input request for this output |
| flit_in | input | NUM_IN*FLIT_W | Flits of all inputs, input i in slice i |
| out_valid | output | 1 | Output word is meaningful |
| out_coded | output | 1 | Output word is the XOR of two or more flits |
| out_flit | output | FLIT_W | Output word |
| grant | output | NUM_IN | Inputs whose flits are combined this cycle |
| pop | output | NUM_IN | One-hot: input counted as delivered this cycle |

## Verification
The assertions assume that every requester keeps `req` high and holds its flit stable until it sees its own `pop`. The freeze and shrink properties depend on that assumption. The stimulus drives every input on the falling edge. A request is released only in the cycle after its pop. New requesters appear only as extra inputs during a run, never as replacements for a member of the frozen set. The bench checks the order of pops against the round-robin pointer it tracks for itself, and checks the output word against XORs it computes from its own flit table.

// File: rtl/xs_pkg.sv
package xs_pkg;
  localparam int XS_PORTS  = 5;
  localparam int XS_FLIT_W = 64;

  // Wrapping increment of an input index.
  function automatic int xs_wrap_inc(input int idx, input int n);
    return (idx >= n - 1) ? 0 : idx + 1;
  endfunction
endpackage

// File: rtl/xs_seq_hold.sv
module xs_seq_hold #(
  parameter int NUM_IN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] req,
  input  logic [NUM_IN-1:0] pop,
  output logic [NUM_IN-1:0] admit
);
  logic              busy_q;
  logic [NUM_IN-1:0] set_q;
  logic [NUM_IN-1:0] left_over;

  // A run in progress admits only the frozen set; otherwise all requesters.
  always_comb begin
    if (busy_q) admit = set_q & req;
    else        admit = req;
  end

  assign left_over = admit & ~pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      set_q  <= '0;
    end else begin
      busy_q <= |left_over;
      set_q  <= left_over;
    end
  end
endmodule

// File: rtl/xs_rr_arb.sv
module xs_rr_arb #(
  parameter int NUM_IN = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_IN-1:0] cand,
  output logic [NUM_IN-1:0] win_oh
);
  localparam int IW = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic [IW-1:0] ptr_q;
  logic [IW-1:0] win_idx;
  logic          found;
  logic [IW:0]   probe;

  // Search upward from the pointer, wrapping once.
  always_comb begin
    win_oh  = '0;
    win_idx = ptr_q;
    found   = 1'b0;
    probe   = '0;
    for (int k = 0; k < NUM_IN; k++) begin
      probe = {1'b0, ptr_q} + (IW+1)'(k);
      if (probe >= (IW+1)'(NUM_IN)) probe = probe - (IW+1)'(NUM_IN);
      if (!found && cand[probe[IW-1:0]]) begin
        found                 = 1'b1;
        win_oh[probe[IW-1:0]] = 1'b1;
        win_idx               = probe[IW-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else if (found) begin
      ptr_q <= IW'(xs_pkg::xs_wrap_inc(int'(win_idx), NUM_IN));
    end
  end
endmodule

// File: rtl/xs_xor_fold.sv
module xs_xor_fold #(
  parameter int NUM_IN = 5,
  parameter int FLIT_W = 64
) (
  input  logic [NUM_IN-1:0]        sel,
  input  logic [NUM_IN*FLIT_W-1:0] flits,
  output logic [FLIT_W-1:0]        folded
);
  logic [NUM_IN-1:0][FLIT_W-1:0] masked;

  for (genvar g = 0; g < NUM_IN; g++) begin : g_mask
    assign masked[g] = sel[g] ? flits[g*FLIT_W +: FLIT_W] : '0;
  end

  always_comb begin
    folded = '0;
    for (int i = 0; i < NUM_IN; i++) folded = folded ^ masked[i];
  end
endmodule

// File: rtl/xor_switch_port.sv
module xor_switch_port #(
  parameter int NUM_IN = xs_pkg::XS_PORTS,
  parameter int FLIT_W = xs_pkg::XS_FLIT_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [NUM_IN-1:0]        req,
  input  logic [NUM_IN*FLIT_W-1:0] flit_in,
  output logic                     out_valid,
  output logic                     out_coded,
  output logic [FLIT_W-1:0]        out_flit,
  output logic [NUM_IN-1:0]        grant,
  output logic [NUM_IN-1:0]        pop
);
  logic [NUM_IN-1:0] admit;
  logic [NUM_IN-1:0] win_oh;

  xs_seq_hold #(.NUM_IN(NUM_IN)) u_hold (
    .clk(clk), .rst(rst), .req(req), .pop(win_oh), .admit(admit)
  );

  xs_rr_arb #(.NUM_IN(NUM_IN)) u_arb (
    .clk(clk), .rst(rst), .cand(admit), .win_oh(win_oh)
  );

  xs_xor_fold #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W)) u_fold (
    .sel(admit), .flits(flit_in), .folded(out_flit)
  );

  assign out_valid = |admit;
  assign out_coded = |(admit & (admit - NUM_IN'(1)));
  assign grant     = admit;
  assign pop       = win_oh;
endmodule

// File: rtl/xs_port_chk.sv
module xs_port_chk #(
  parameter int NUM_IN = 5,
  parameter int FLIT_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic [NUM_IN-1:0] req,
  input logic              out_valid,
  input logic              out_coded,
  input logic [FLIT_W-1:0] out_flit,
  input logic [NUM_IN-1:0] grant,
  input logic [NUM_IN-1:0] pop
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (req == '0) |-> (!out_valid && !out_coded && out_flit == '0 && pop == '0));

  // R2
  single_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_coded) |-> (pop == grant));

  // R4
  one_pop_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(pop) == 1 && (pop & ~grant) == '0));

  // R5
  shrink_chk: assert property (@(posedge clk) disable iff (rst)
    (|(grant & ~pop)) |=> ((grant & ~$past(grant & ~pop)) == '0));

  // R7
  hold_off_chk: assert property (@(posedge clk) disable iff (rst)
    out_coded |=> ((pop & ~$past(grant)) == '0));

  // R3
  coded_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_coded |-> out_valid);
endmodule

bind xor_switch_port xs_port_chk #(.NUM_IN(NUM_IN), .FLIT_W(FLIT_W)) u_chk (
  .clk(clk), .rst(rst), .req(req), .out_valid(out_valid), .out_coded(out_coded),
  .out_flit(out_flit), .grant(grant), .pop(pop)
);

// File: tb/sim_xor_switch_port.sv
module sim_xor_switch_port;
  localparam int N = 5;
  localparam int W = 64;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [N-1:0]   req = '0;
  logic [N*W-1:0] flit_in;
  logic           out_valid, out_coded;
  logic [W-1:0]   out_flit;
  logic [N-1:0]   grant, pop;

  logic [W-1:0] dat [N];
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xor_switch_port #(.NUM_IN(N), .FLIT_W(W)) u0 (
    .clk(clk), .rst(rst), .req(req), .flit_in(flit_in),
    .out_valid(out_valid), .out_coded(out_coded), .out_flit(out_flit),
    .grant(grant), .pop(pop)
  );

  always_comb
    for (int i = 0; i < N; i++) flit_in[i*W +: W] = dat[i];

  function automatic logic [W-1:0] xor_of(input logic [N-1:0] m);
    logic [W-1:0] a = '0;
    for (int i = 0; i < N; i++) if (m[i]) a ^= dat[i];
    return a;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive on the falling edge, sample 1 ns later.
  task automatic drive(input logic [N-1:0] r);
    @(negedge clk);
    req = r;
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [N-1:0] eg, input logic [N-1:0] ep,
                            input logic ev, input logic ec, input logic [W-1:0] ef);
    chk({tag, " grant"}, W'(grant), W'(eg));
    chk({tag, " pop"},   W'(pop),   W'(ep));
    chk({tag, " valid"}, W'(out_valid), W'(ev));
    chk({tag, " coded"}, W'(out_coded), W'(ec));
    chk({tag, " flit"},  out_flit, ef);
  endtask

  task automatic t_reset_idle();
    drive('0);
    expect_out("R1 R9 idle", '0, '0, 0, 0, '0);
  endtask

  task automatic t_single();
    drive(5'b00100);
    expect_out("R2 single", 5'b00100, 5'b00100, 1, 0, dat[2]);
  endtask

  // Pointer at 3 after t_single.
  task automatic t_triple();
    logic [W-1:0] w1, w2, w3;
    drive(5'b10011);
    expect_out("R3 R6 triple c1", 5'b10011, 5'b10000, 1, 1, dat[0] ^ dat[1] ^ dat[4]);
    w1 = out_flit;
    drive(5'b00011);
    expect_out("R5 R6 triple c2", 5'b00011, 5'b00001, 1, 1, dat[0] ^ dat[1]);
    w2 = out_flit;
    chk("R8 decode first", w1 ^ w2, dat[4]);
    drive(5'b00010);
    expect_out("R5 triple last uncoded", 5'b00010, 5'b00010, 1, 0, dat[1]);
    w3 = out_flit;
    chk("R8 decode second", w2 ^ w3, dat[0]);
  endtask

  // Pointer at 2.
  task automatic t_hold_off();
    drive(5'b01010);
    expect_out("R6 hold c1", 5'b01010, 5'b01000, 1, 1, dat[1] ^ dat[3]);
    drive(5'b00111);
    expect_out("R7 newcomers held", 5'b00010, 5'b00010, 1, 0, dat[1]);
    drive(5'b00101);
    expect_out("R7 newcomers served", 5'b00101, 5'b00100, 1, 1, dat[0] ^ dat[2]);
    drive(5'b00001);
    expect_out("R5 hold tail", 5'b00001, 5'b00001, 1, 0, dat[0]);
    drive('0);
    expect_out("R1 after drain", '0, '0, 0, 0, '0);
  endtask

  // Pointer at 1: all five collide, pops go 1,2,3,4,0.
  task automatic t_all_five();
    logic [N-1:0] rem = '1;
    logic [W-1:0] prev = '0;
    for (int s = 0; s < N; s++) begin
      int w = (1 + s) % N;
      drive(rem);
      expect_out($sformatf("R4 R5 R6 all step%0d", s), rem, N'(1) << w, 1,
                 (s < N - 1), xor_of(rem));
      if (s > 0) chk($sformatf("R8 all decode%0d", s), prev ^ out_flit, dat[(s) % N]);
      prev = out_flit;
      rem[w] = 1'b0;
    end
  endtask

  // Pointer at 1 again; reset mid-run clears the frozen set and pointer.
  task automatic t_reset_mid();
    drive(5'b00011);
    expect_out("R6 pre-reset", 5'b00011, 5'b00010, 1, 1, dat[0] ^ dat[1]);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    req = 5'b01001;
    #1;
    expect_out("R9 fresh set after reset", 5'b01001, 5'b00001, 1, 1, dat[0] ^ dat[3]);
    drive(5'b01000);
    expect_out("R9 tail after reset", 5'b01000, 5'b01000, 1, 0, dat[3]);
  endtask

  initial begin
    for (int i = 0; i < N; i++)
      dat[i] = {16'h5A00 + 16'(i), 16'h1111 * 16'(i + 1), 32'hC0DE_0000 | 32'(i * 37)};
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset_idle();
    t_single();
    t_triple();
    t_hold_off();
    t_all_five();
    t_reset_mid();
    drive('0);
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule